// File: doc/BRIEF.md
# Next Program Counter Unit

This block works out where a 32-bit RISC core fetches next. The core has fixed 4-byte, word-aligned instructions. Each cycle the core presents the current fetch address and a control-flow kind. The kind selects one of: plain sequential flow, a branch taken when the two register operands are equal, a branch taken when they differ, a direct jump, a direct jump that also saves a return address, or a jump to an address held in a register. Alongside the kind come the two comparison operands, a 16-bit signed branch offset counted in words, a 26-bit direct-jump target field and the register value for register-indirect jumps.

Every path starts from the address of the following instruction (current address plus four). Branches add the sign-extended offset, scaled to bytes, to that address. Direct jumps keep its top four bits and fill the rest from the target field scaled to bytes. The unit also produces a write enable and a data value for the return-address register (register 31), plus a flag for a misaligned register-indirect target. All results are registered, so they appear one clock after the inputs. A synchronous active-high reset puts the next address at a parameterised start address.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs become `next_pc_o` = RESET_PC (default 0), `link_we_o` = 0, `link_val_o` = 0 and `misalign_o` = 0.
- R2: Kind code 0 (sequential) and the unused codes 6 and 7 give `next_pc_o` = pc + 4.
- R3: Kind code 1 (branch on equal) gives pc + 4 + (sign-extended offset × 4) when `opa_i` == `opb_i`, and pc + 4 otherwise.
- R4: Kind code 2 (branch on not equal) gives pc + 4 + (sign-extended offset × 4) when `opa_i` != `opb_i`, and pc + 4 otherwise.
- R5: Kind code 3 (direct jump) gives bits [31:28] from pc + 4, bits [27:2] from `jtgt_i`, and bits [1:0] = 0.
- R6: Kind code 4 (jump and save return) gives the same next address as code 3, with `link_we_o` = 1.
- R7: Kind code 5 (register jump) gives `next_pc_o` = `jreg_i`. It raises `misalign_o` exactly when `jreg_i[1:0]` is non-zero; other kinds never raise `misalign_o`.
- R8: `link_we_o` is 1 only for kind code 4. `link_val_o` always carries pc + 4.
- R9: Every result is registered. It reflects the inputs sampled at the previous rising edge, and a new result appears every cycle.
- R10: Address arithmetic wraps modulo 2^32; for example, pc 0xFFFFFFFC in sequential flow gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Current fetch address |
| kind_i | input | 3 | Control-flow kind code |
| opa_i | input | 32 | First comparison operand |
| opb_i | input | 32 | Second comparison operand |
| ofs_i | input | 16 | Signed branch offset in words |
| jtgt_i | input | 26 | Direct-jump target field in words |
| jreg_i | input | 32 | Register-indirect jump address |
| next_pc_o | output | 32 | Registered next fetch address |
| link_we_o | output | 1 | Write enable for register 31 |
| link_val_o | output | 32 | Return address (pc + 4) |
| misalign_o | output | 1 | Register-jump target not word-aligned |

## Verification
Every output is due exactly one rising edge after the inputs that produce it. The bench changes inputs on a falling edge, lets one rising edge pass, and compares all four outputs on the next falling edge, before the next stimulus goes on. Reset values are read the same way, one edge after `rst` is raised. The sweep crosses every kind code with boundary fetch addresses, extreme positive and negative offsets, extreme target fields, equal and unequal operands, and all four low-bit patterns of the register target.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    CF_SEQ  = 3'd0,
    CF_BEQ  = 3'd1,
    CF_BNE  = 3'd2,
    CF_JMP  = 3'd3,
    CF_JAL  = 3'd4,
    CF_JREG = 3'd5
  } cf_kind_e;
endpackage

// File: rtl/npc_cmp.sv
module npc_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            eq_o
);
  logic [XLEN-1:0] diff;
  always_comb begin
    diff = a_i ^ b_i;
    eq_o = ~(|diff);
  end
endmodule

// File: rtl/npc_addr.sv
module npc_addr #(
  parameter int XLEN  = 32,
  parameter int OFS_W = 16,
  parameter int TGT_W = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic [XLEN-1:0]  seq_o,
  output logic [XLEN-1:0]  br_o,
  output logic [XLEN-1:0]  jmp_o
);
  localparam int SX_W = XLEN - OFS_W - 2;
  localparam int HI_W = XLEN - TGT_W - 2;

  logic [XLEN-1:0] ofs_bytes;

  always_comb begin
    seq_o     = pc_i + XLEN'(4);
    ofs_bytes = {{SX_W{ofs_i[OFS_W-1]}}, ofs_i, 2'b00};
    br_o      = seq_o + ofs_bytes;
    jmp_o     = {seq_o[XLEN-1 -: HI_W], tgt_i, 2'b00};
  end
endmodule

// File: rtl/npc_sel.sv
module npc_sel #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      kind_i,
  input  logic            eq_i,
  input  logic [XLEN-1:0] seq_i,
  input  logic [XLEN-1:0] br_i,
  input  logic [XLEN-1:0] jmp_i,
  input  logic [XLEN-1:0] jreg_i,
  output logic [XLEN-1:0] next_o,
  output logic            link_o,
  output logic            fault_o
);
  import npc_pkg::*;
  cf_kind_e kind;

  always_comb begin
    kind    = cf_kind_e'(kind_i);
    next_o  = seq_i;
    link_o  = 1'b0;
    fault_o = 1'b0;
    case (kind)
      CF_BEQ:  if (eq_i)  next_o = br_i;
      CF_BNE:  if (!eq_i) next_o = br_i;
      CF_JMP:  next_o = jmp_i;
      CF_JAL:  begin next_o = jmp_i; link_o = 1'b1; end
      CF_JREG: begin next_o = jreg_i; fault_o = |jreg_i[1:0]; end
      default: next_o = seq_i;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int          XLEN     = 32,
  parameter int          OFS_W    = 16,
  parameter int          TGT_W    = 26,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [2:0]       kind_i,
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [TGT_W-1:0] jtgt_i,
  input  logic [XLEN-1:0]  jreg_i,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             link_we_o,
  output logic [XLEN-1:0]  link_val_o,
  output logic             misalign_o
);
  import npc_pkg::*;
  localparam int HI_W = XLEN - TGT_W - 2;

  logic            eq;
  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc, nxt;
  logic            link, fault;

  npc_cmp #(.XLEN(XLEN)) u_cmp (.a_i(opa_i), .b_i(opb_i), .eq_o(eq));

  npc_addr #(.XLEN(XLEN), .OFS_W(OFS_W), .TGT_W(TGT_W)) u_addr (
    .pc_i(pc_i), .ofs_i(ofs_i), .tgt_i(jtgt_i),
    .seq_o(seq_pc), .br_o(br_pc), .jmp_o(jmp_pc));

  npc_sel #(.XLEN(XLEN)) u_sel (
    .kind_i(kind_i), .eq_i(eq), .seq_i(seq_pc), .br_i(br_pc),
    .jmp_i(jmp_pc), .jreg_i(jreg_i),
    .next_o(nxt), .link_o(link), .fault_o(fault));

  // R9: one register stage on every result
  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc_o  <= XLEN'(RESET_PC);
      link_we_o  <= 1'b0;
      link_val_o <= '0;
      misalign_o <= 1'b0;
    end else begin
      next_pc_o  <= nxt;
      link_we_o  <= link;
      link_val_o <= seq_pc;
      misalign_o <= fault;
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  a_r8_link_only_jal: assert property (@(posedge clk) disable iff (rst)
    (past_ok && link_we_o) |-> ($past(kind_i) == 3'(CF_JAL)));
  a_r8_link_value: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (link_val_o == $past(pc_i) + XLEN'(4)));
  a_r7_fault_only_jreg: assert property (@(posedge clk) disable iff (rst)
    (past_ok && misalign_o) |-> ($past(kind_i) == 3'(CF_JREG)));
  a_r7_jreg_target: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(kind_i) == 3'(CF_JREG)) |-> (next_pc_o == $past(jreg_i)));
  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(kind_i) == 3'(CF_SEQ)) |-> (next_pc_o == $past(pc_i) + XLEN'(4)));
  a_r5_jump_upper: assert property (@(posedge clk) disable iff (rst)
    (past_ok && ($past(kind_i) == 3'(CF_JMP) || $past(kind_i) == 3'(CF_JAL)))
    |-> (next_pc_o[XLEN-1 -: HI_W] == $past(pc_i[XLEN-1 -: HI_W] + HI_W'(pc_i[XLEN-HI_W-1:2] == '1))
         && next_pc_o[1:0] == 2'b00));
endmodule

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] pc, opa, opb, jreg;
  logic [2:0]  kind;
  logic [15:0] ofs;
  logic [25:0] jtgt;
  logic [31:0] next_pc, link_val;
  logic        link_we, misalign;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  npc_unit u0 (
    .clk(clk), .rst(rst), .pc_i(pc), .kind_i(kind), .opa_i(opa), .opb_i(opb),
    .ofs_i(ofs), .jtgt_i(jtgt), .jreg_i(jreg),
    .next_pc_o(next_pc), .link_we_o(link_we), .link_val_o(link_val),
    .misalign_o(misalign));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] k);
    case (k)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R2";
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pcs [4];
    logic [15:0] ofss [4];
    logic [25:0] tgts [4];
    logic [31:0] p4, expn, boff;
    logic        taken;
    pcs[0] = 32'h0040_0000; pcs[1] = 32'h1FFF_FFF0;
    pcs[2] = 32'h8000_1234; pcs[3] = 32'hFFFF_FFFC;
    ofss[0] = 16'h0000; ofss[1] = 16'h7FFF; ofss[2] = 16'h8000; ofss[3] = 16'hFFFF;
    tgts[0] = 26'h0; tgts[1] = 26'h3FF_FFFF; tgts[2] = 26'h123_4567; tgts[3] = 26'h2AA_AAAA;

    rst = 1'b1; pc = 32'h1234_5678; kind = 3'd4; opa = 0; opb = 0;
    ofs = 0; jtgt = 0; jreg = 32'h3;
    repeat (3) @(negedge clk);
    chk("R1 next_pc", next_pc, 32'h0);
    chk("R1 link_we", {31'b0, link_we}, 32'h0);
    chk("R1 link_val", link_val, 32'h0);
    chk("R1 misalign", {31'b0, misalign}, 32'h0);
    rst = 1'b0;

    for (int k = 0; k < 8; k++)
      for (int pi = 0; pi < 4; pi++)
        for (int oi = 0; oi < 4; oi++)
          for (int e = 0; e < 2; e++)
            for (int lo = 0; lo < 4; lo++) begin
              kind = 3'(k); pc = pcs[pi]; ofs = ofss[oi]; jtgt = tgts[oi];
              opa  = pcs[pi] ^ 32'h55AA_0F0F;
              opb  = (e == 1) ? opa : (opa ^ (32'h1 << (oi * 7 + lo)));
              jreg = 32'h0040_0100 + (32'(pi) << 8) + 32'(lo);
              @(posedge clk);
              @(negedge clk);
              // R9: result of the inputs captured at the last rising edge
              p4   = pc + 32'd4;
              boff = 32'(int'($signed(ofs)) * 4);
              taken = (k == 1 && e == 1) || (k == 2 && e == 0);
              case (k)
                1, 2:    expn = taken ? p4 + boff : p4;
                3, 4:    expn = (p4 & 32'hF000_0000) | (32'(jtgt) * 4);
                5:       expn = jreg;
                default: expn = p4;
              endcase
              chk({tag_of(kind), " R9 R10 next_pc"}, next_pc, expn);
              chk("R8 link_val", link_val, p4);
              chk("R8 R6 link_we", {31'b0, link_we}, (k == 4) ? 32'h1 : 32'h0);
              chk("R7 misalign", {31'b0, misalign}, (k == 5 && lo != 0) ? 32'h1 : 32'h0);
            end

    // R10: explicit wrap
    kind = 3'd0; pc = 32'hFFFF_FFFC;
    @(posedge clk); @(negedge clk);
    chk("R10 wrap", next_pc, 32'h0);

    // R1: reset in mid run
    rst = 1'b1; kind = 3'd5; jreg = 32'h0000_0007;
    @(posedge clk); @(negedge clk);
    chk("R1 mid next_pc", next_pc, 32'h0);
    chk("R1 mid misalign", {31'b0, misalign}, 32'h0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule